// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Detection

This block recovers asynchronous characters from one serial line. A 16X oversampling clock enable paces it. Each character starts with a low start bit, carries 5 to 8 data bits least significant bit first, may carry a parity bit, and ends with one stop bit.

Each finished character appears on a valid/ready output. The character comes with its parity error, framing error and compare-match flags, plus an overrun flag for a character that was lost behind it. Static inputs choose the character length, the parity rule and whether reception is enabled.

A low glitch shorter than half a bit is discarded. After a framing error the receiver hunts for a new start bit half a bit after the stop sample, without waiting for a line idle. A received break raises one pulse when it begins and another when the line returns high.

Top module: `async_rx_brk`

## Requirements
- R1: `len_sel` picks the data length as 5 + `len_sel` bits (0 gives 5, 3 gives 8). The first data bit after the start bit lands in `out_data[0]`, and bits above the chosen length read zero.
- R2: `par_sel` picks the parity rule. 0 means no parity bit. 1 means even: the parity bit equals the XOR of the data bits. 2 means odd: the parity bit equals the inverted XOR. 3 means forced: the parity bit must equal `par_fix`. A parity bit is present on the line only when `par_sel` is not 0.
- R3: `out_par_err` is 1 when the received parity bit breaks the selected rule, and 0 otherwise. It is always 0 with `par_sel` = 0.
- R4: A start bit is taken only if the line is still low 8 ticks after the falling edge was seen. A shorter low pulse produces no character and leaves the receiver ready for the next start bit.
- R5: `out_match` is 1 when the received data bits equal `cmp_char`. Only the bits inside the chosen length are compared.
- R6: A stop bit sampled low gives `out_frm_err` = 1, and the character is still delivered. A stop bit sampled high gives `out_frm_err` = 0.
- R7: After a framing error that is not a break, the start-bit hunt resumes 8 ticks after the stop sample. A start bit that directly follows a low stop bit is therefore received without any idle time between them.
- R8: A character whose data bits are all zero with a low stop bit is a break. `brk_start` pulses for one cycle together with its delivery. `brk_end` pulses once, on the first tick that sees the line high afterwards, and never while the line stays low.
- R9: `out_valid` holds, with `out_data` unchanged, until `out_ready` is 1. A character that completes while the held one is unread is dropped, and `out_ovr` is set on the held character.
- R10: While `rx_en` is 0 the receiver stays idle: no character and no break pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| len_sel | input | 2 | Data length code, bits = 5 + code |
| par_sel | input | 2 | Parity rule: 0 none, 1 even, 2 odd, 3 forced |
| par_fix | input | 1 | Parity bit value expected in forced mode |
| cmp_char | input | 8 | Compare value for match detection |
| out_valid | output | 1 | Held character available |
| out_ready | input | 1 | Consumer takes the held character |
| out_data | output | 8 | Received data, zero-extended |
| out_par_err | output | 1 | Parity error of held character |
| out_frm_err | output | 1 | Framing error of held character |
| out_ovr | output | 1 | A later character was lost while this one was held |
| out_match | output | 1 | Held character equals compare value |
| brk_start | output | 1 | One-cycle pulse: break received |
| brk_end | output | 1 | One-cycle pulse: line high after break |

## Verification
On every cycle the assertions check several relations. A delivered character never has data bits above its length, and a clean stop bit was really sampled high. A break end is only reported on a high line. Nothing is delivered while disabled, and a held character stays stable until taken, with overrun marked when a newer one arrives. Only the bench scenarios can show the rest: correct bit order and parity under every mode and length, rejection of a short glitch, back-to-back recovery after a framing error with no idle gap, and the exact ordering of break start and end against the line.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int DW      = 8;
    localparam int MIN_LEN = 5;
    localparam int IW      = $clog2(DW);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK, ST_RESYNC
    } rx_state_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0, PM_EVEN = 2'd1, PM_ODD = 2'd2, PM_FIXED = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          par_err;
        logic          frm_err;
        logic          match;
    } rx_char_t;
endpackage

// File: rtl/rxb_sync.sv
module rxb_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] s_d, s_q;

    always_comb s_d = {s_q[STAGES-2:0], d_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= {STAGES{RST_VAL}};
        else        s_q <= s_d;
    end

    assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/rxb_check.sv
module rxb_check
    import rxb_pkg::*;
(
    input  logic [DW-1:0] data_i,
    input  logic          pbit_i,
    input  logic [1:0]    len_i,
    input  logic [1:0]    par_i,
    input  logic          fix_i,
    input  logic [DW-1:0] cmp_i,
    output logic          par_err_o,
    output logic          match_o
);
    logic [DW-1:0] mask;
    logic          ones;

    always_comb begin
        mask = {DW{1'b1}} >> (2'd3 - len_i);
        ones = ^(data_i & mask);
        unique case (par_mode_e'(par_i))
            PM_EVEN:  par_err_o = (pbit_i != ones);
            PM_ODD:   par_err_o = (pbit_i == ones);
            PM_FIXED: par_err_o = (pbit_i != fix_i);
            default:  par_err_o = 1'b0;
        endcase
        match_o = ((data_i & mask) == (cmp_i & mask));
    end
endmodule

// File: rtl/rxb_frame.sv
module rxb_frame
    import rxb_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  logic          en_i,
    input  logic [1:0]    len_i,
    input  logic [1:0]    par_i,
    input  logic          fix_i,
    input  logic [DW-1:0] cmp_i,
    output logic          push_o,
    output rx_char_t      char_o,
    output logic          brk_start_o,
    output logic          brk_end_o
);
    localparam int CW   = $clog2(OS);
    localparam int HALF = OS / 2;

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        logic          pbit;
        logic          push;
        logic          bs;
        logic          be;
        rx_char_t      ch;
    } fr_t;

    fr_t fr_d, fr_q;
    logic perr, mtch;
    logic [IW-1:0] last_idx;

    rxb_check u_chk (
        .data_i   (fr_q.data),
        .pbit_i   (fr_q.pbit),
        .len_i    (len_i),
        .par_i    (par_i),
        .fix_i    (fix_i),
        .cmp_i    (cmp_i),
        .par_err_o(perr),
        .match_o  (mtch)
    );

    always_comb begin
        last_idx = IW'(MIN_LEN - 1) + IW'(len_i);
        fr_d      = fr_q;
        fr_d.push = 1'b0;
        fr_d.bs   = 1'b0;
        fr_d.be   = 1'b0;
        if (!en_i) begin
            fr_d.st  = ST_IDLE;
            fr_d.cnt = '0;
        end else if (tick_i) begin
            unique case (fr_q.st)
                ST_IDLE: if (!rx_i) begin
                    fr_d.st  = ST_START;
                    fr_d.cnt = '0;
                end
                ST_START: if (fr_q.cnt == CW'(HALF - 1)) begin
                    fr_d.cnt = '0;
                    if (!rx_i) begin
                        fr_d.st   = ST_DATA;
                        fr_d.idx  = '0;
                        fr_d.data = '0;
                    end else begin
                        fr_d.st = ST_IDLE;
                    end
                end else fr_d.cnt = fr_q.cnt + 1'b1;
                ST_DATA: if (fr_q.cnt == CW'(OS - 1)) begin
                    fr_d.cnt = '0;
                    fr_d.data[fr_q.idx] = rx_i;
                    if (fr_q.idx == last_idx)
                        fr_d.st = (par_mode_e'(par_i) == PM_NONE) ? ST_STOP : ST_PAR;
                    else
                        fr_d.idx = fr_q.idx + 1'b1;
                end else fr_d.cnt = fr_q.cnt + 1'b1;
                ST_PAR: if (fr_q.cnt == CW'(OS - 1)) begin
                    fr_d.cnt  = '0;
                    fr_d.pbit = rx_i;
                    fr_d.st   = ST_STOP;
                end else fr_d.cnt = fr_q.cnt + 1'b1;
                ST_STOP: if (fr_q.cnt == CW'(OS - 1)) begin
                    fr_d.cnt        = '0;
                    fr_d.push       = 1'b1;
                    fr_d.ch.data    = fr_q.data;
                    fr_d.ch.par_err = perr;
                    fr_d.ch.frm_err = !rx_i;
                    fr_d.ch.match   = mtch;
                    if (rx_i) begin
                        fr_d.st = ST_IDLE;
                    end else if (fr_q.data == '0) begin
                        fr_d.bs = 1'b1;
                        fr_d.st = ST_BRK;
                    end else begin
                        fr_d.st = ST_RESYNC;
                    end
                end else fr_d.cnt = fr_q.cnt + 1'b1;
                ST_BRK: if (rx_i) begin
                    fr_d.be = 1'b1;
                    fr_d.st = ST_IDLE;
                end
                ST_RESYNC: if (fr_q.cnt == CW'(HALF - 1)) begin
                    fr_d.cnt = '0;
                    fr_d.st  = ST_IDLE;
                end else fr_d.cnt = fr_q.cnt + 1'b1;
                default: fr_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= ST_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign push_o      = fr_q.push;
    assign char_o      = fr_q.ch;
    assign brk_start_o = fr_q.bs;
    assign brk_end_o   = fr_q.be;

    // R1
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ((char_o.data >> (MIN_LEN + int'(len_i))) == '0));
    // R6
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o && !char_o.frm_err |-> $past(rx_i));
    // R8
    brk_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end_o |-> $past(rx_i));
    // R8
    brk_with_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start_o |-> push_o && char_o.frm_err);
    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !push_o && !brk_start_o && !brk_end_o);
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
    import rxb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  rx_char_t char_i,
    input  logic     ready_i,
    output logic     valid_o,
    output rx_char_t char_o,
    output logic     ovr_o
);
    typedef struct packed {
        logic     valid;
        rx_char_t ch;
        logic     ovr;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (push_i) begin
            if (h_q.valid && !ready_i) begin
                h_d.ovr = 1'b1;
            end else begin
                h_d.valid = 1'b1;
                h_d.ch    = char_i;
                h_d.ovr   = 1'b0;
            end
        end else if (h_q.valid && ready_i) begin
            h_d.valid = 1'b0;
            h_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign valid_o = h_q.valid;
    assign char_o  = h_q.ch;
    assign ovr_o   = h_q.ovr;

    // R9
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(char_o.data));
    // R9
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && valid_o && !ready_i |=> ovr_o);
endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk
    import rxb_pkg::*;
#(
    parameter int OS          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rx_in,
    input  logic          rx_en,
    input  logic [1:0]    len_sel,
    input  logic [1:0]    par_sel,
    input  logic          par_fix,
    input  logic [DW-1:0] cmp_char,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_par_err,
    output logic          out_frm_err,
    output logic          out_ovr,
    output logic          out_match,
    output logic          brk_start,
    output logic          brk_end
);
    logic     rx_s;
    logic     push;
    rx_char_t new_ch, held_ch;

    rxb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_in), .q_o(rx_s)
    );

    rxb_frame #(.OS(OS)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick16), .rx_i(rx_s), .en_i(rx_en),
        .len_i(len_sel), .par_i(par_sel), .fix_i(par_fix), .cmp_i(cmp_char),
        .push_o(push), .char_o(new_ch), .brk_start_o(brk_start), .brk_end_o(brk_end)
    );

    rxb_hold u_hold (
        .clk(clk), .rst_n(rst_n), .push_i(push), .char_i(new_ch),
        .ready_i(out_ready), .valid_o(out_valid), .char_o(held_ch), .ovr_o(out_ovr)
    );

    assign out_data    = held_ch.data;
    assign out_par_err = held_ch.par_err;
    assign out_frm_err = held_ch.frm_err;
    assign out_match   = held_ch.match;
endmodule

// File: tb/async_rx_brk_tb.sv
module async_rx_brk_tb;
    localparam int TP = 2;
    localparam int BT = 16 * TP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tcnt = 1'b0;
    logic tick16;
    logic rx_in = 1'b1, rx_en = 1'b1, par_fix = 1'b0, out_ready = 1'b0;
    logic [1:0] len_sel = 2'd3, par_sel = 2'd0;
    logic [7:0] cmp_char = 8'h00;
    logic out_valid, out_par_err, out_frm_err, out_ovr, out_match, brk_start, brk_end;
    logic [7:0] out_data;

    int n_run = 0, n_fail = 0, n_bs = 0, n_be = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) begin
        tcnt <= ~tcnt;
        cyc  <= cyc + 1;
        if (brk_start) n_bs <= n_bs + 1;
        if (brk_end)   n_be <= n_be + 1;
    end
    assign tick16 = tcnt;

    async_rx_brk u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in), .rx_en(rx_en),
        .len_sel(len_sel), .par_sel(par_sel), .par_fix(par_fix), .cmp_char(cmp_char),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_par_err(out_par_err), .out_frm_err(out_frm_err), .out_ovr(out_ovr),
        .out_match(out_match), .brk_start(brk_start), .brk_end(brk_end)
    );

    function automatic logic [7:0] lmask(input logic [1:0] l);
        return 8'hFF >> (3 - l);
    endfunction

    function automatic logic pbit_for(input logic [1:0] pm, input logic [7:0] d, input logic fx);
        case (pm)
            2'd1: return ^d;
            2'd2: return ~(^d);
            default: return fx;
        endcase
    endfunction

    task automatic hold_line(input logic v, input int clocks);
        rx_in = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic stop, input int idle_bits);
        hold_line(1'b0, BT);
        for (int i = 0; i < 5 + len_sel; i++) hold_line(d[i], BT);
        if (par_sel != 2'd0) hold_line(pbit_for(par_sel, d, par_fix) ^ bad_par, BT);
        hold_line(stop, BT);
        if (idle_bits > 0) hold_line(1'b1, idle_bits * BT);
    endtask

    task automatic check1(input string req, input logic got, input logic exp, input string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic expect_char(input string req, input logic [7:0] d, input logic pe,
                               input logic fe, input logic ov, input logic m);
        n_run++;
        if (!out_valid || out_data !== d || out_par_err !== pe || out_frm_err !== fe
            || out_ovr !== ov || out_match !== m) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b d=%02h pe=%0b fe=%0b ov=%0b m=%0b expected v=1 d=%02h pe=%0b fe=%0b ov=%0b m=%0b",
                     req, out_valid, out_data, out_par_err, out_frm_err, out_ovr, out_match,
                     d, pe, fe, ov, m);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        while (!done && cyc < 190000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, m, c;
        int bs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // reset state
        check1("R9", out_valid, 1'b0, "valid after reset");
        check1("R8", brk_start | brk_end, 1'b0, "break pulses after reset");
        hold_line(1'b1, 2 * BT);

        // R1 R2 R3 R5: sweep over lengths, parity rules and data patterns
        for (int l = 0; l < 4; l++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int k = 0; k < 8; k++) begin
                    len_sel = 2'(l); par_sel = 2'(pm); par_fix = k[0];
                    m = lmask(len_sel);
                    d = 8'(k * 37 + l * 11 + pm * 5 + 3) & m;
                    case (k % 3)
                        0: c = d;
                        1: c = d ^ 8'h01;
                        default: c = d ^ 8'h80;
                    endcase
                    cmp_char = c;
                    send(d, 1'b0, 1'b1, 1);
                    expect_char("R1/R2/R5 sweep", d, 1'b0, 1'b0, 1'b0, (d & m) == (c & m));
                end
            end
        end

        // R3: wrong parity bit under each rule
        len_sel = 2'd2; cmp_char = 8'h00;
        for (int pm = 1; pm < 4; pm++) begin
            par_sel = 2'(pm); par_fix = 1'b1;
            send(8'h35, 1'b1, 1'b1, 1);
            expect_char("R3 parity error", 8'h35, 1'b1, 1'b0, 1'b0, 1'b0);
        end

        // R4: short low glitch then a real character
        len_sel = 2'd3; par_sel = 2'd0; cmp_char = 8'hC3;
        hold_line(1'b0, 3 * TP);
        hold_line(1'b1, 3 * BT);
        check1("R4", out_valid, 1'b0, "valid after false start");
        send(8'hC3, 1'b0, 1'b1, 1);
        expect_char("R4 after false start", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);

        // R6 R7: framing error followed by a start bit with no idle
        bs0 = n_bs;
        cmp_char = 8'h00;
        send(8'h5A, 1'b0, 1'b0, 0);
        expect_char("R6 framing error", 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 1'b1, 1);
        expect_char("R7 resync without idle", 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
        check1("R8", n_bs != bs0, 1'b0, "break on non-zero framing error");

        // R8: all-zero data with a clean stop is not a break
        send(8'h00, 1'b0, 1'b1, 1);
        expect_char("R8 zero char no break", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        check1("R8", n_bs != bs0, 1'b0, "break on clean zero char");

        // R8: break start and end
        cmp_char = 8'h11;
        hold_line(1'b0, 16 * BT);
        check1("R8", n_bs == bs0 + 1, 1'b1, "break start count");
        check1("R8", n_be == 0, 1'b1, "no break end while low");
        expect_char("R8 break char", 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        hold_line(1'b1, 2 * BT);
        check1("R8", n_be == 1, 1'b1, "break end count");
        send(8'hA5, 1'b0, 1'b1, 1);
        expect_char("R8 after break", 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: overrun drops the newer character
        send(8'h71, 1'b0, 1'b1, 1);
        send(8'h0E, 1'b0, 1'b1, 1);
        expect_char("R9 overrun", 8'h71, 1'b0, 1'b0, 1'b1, 1'b0);
        check1("R9", out_valid, 1'b0, "dropped char not delivered");
        send(8'h22, 1'b0, 1'b1, 1);
        expect_char("R9 clean after overrun", 8'h22, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: disabled receiver ignores the line
        rx_en = 1'b0;
        send(8'h00, 1'b0, 1'b0, 2);
        check1("R10", out_valid, 1'b0, "valid while disabled");
        check1("R10", n_bs == bs0 + 1, 1'b1, "break while disabled");
        rx_en = 1'b1;
        hold_line(1'b1, BT);
        send(8'h99, 1'b0, 1'b1, 1);
        expect_char("R10 re-enabled", 8'h99, 1'b0, 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule